// File: doc/BRIEF.md
# Instruction queue doorbell controller

This block is the per-queue front end of a command-queue coprocessor. Software rings a doorbell by writing a count of newly available 64-bit instruction words. The block adds that count to a 20-bit pending counter. Whenever the queue is enabled and at least one whole 8-word instruction is pending, it requests a fetch. Each granted fetch uses up 8 words and moves the fetch address on by one 64-byte instruction.

The block keeps an in-flight count of fetched instructions that have not yet completed. It also owns the queue enable and a miscellaneous interrupt status register. That register has per-bit enables, and its bits are set by doorbell overflow and by error pulses from the fetch and engine side. Reconfiguring the buffer start address is accepted only while the queue is disabled and nothing is in flight.

All state sits behind a small CSR port. Writes take effect at the next clock edge. Reads return the selected register combinationally.

Top module: `iq_front`

## Requirements
- R1: A write to CSR address 1 (doorbell) adds the low 20 bits of the write data to the pending word counter. A read of address 1 returns the pending count. Counts that are not a multiple of 8 are accepted as written.
- R2: Bit 0 of CSR address 0 is the queue enable. `fetch_req` is high exactly when the enable is 1, the pending count is at least 8 and the in-flight count is below its maximum (255). Each cycle with `fetch_req` and `fetch_gnt` both high subtracts 8 from the pending count.
- R3: When a doorbell add carries out of the 20-bit counter, the counter keeps the low 20 bits of the sum and status bit 1 (doorbell overflow) is set.
- R4: CSR address 2 holds the instruction buffer address, bits 48:6, with bits 5:0 always zero. A write sets the start address. A read, and the `fetch_addr` output, give the next fetch address, which grows by 64 on each granted fetch.
- R5: CSR address 3 reads the in-flight count. It rises by one on a granted fetch and falls by one on a `cmpl` pulse. A grant and a completion in the same cycle leave it unchanged.
- R6: A write to address 2 is ignored while the enable is 1 or the in-flight count is nonzero.
- R7: CSR address 4 is the misc status register. Its bits are: 0 mailbox, 1 doorbell overflow, 2 instruction read error, 3 result write error, 4 software error, 5 hardware error, 6 translation fault. Writing a 1 to a bit clears it. A pulse on `err_in[i]` sets bit i, and a set pulse wins over a clear in the same cycle.
- R8: Writing ones to address 5 sets status enables, and writing ones to address 6 clears them. Both addresses read back the enables. `irq` is the OR of the status bits that are both set and enabled.
- R9: After reset the pending count, in-flight count, address, enable, status and status enables are all zero, and `fetch_req` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 3 | CSR register select |
| csr_wdata | input | 64 | CSR write data |
| csr_rdata | output | 64 | CSR read data for `csr_addr` (combinational) |
| fetch_req | output | 1 | An instruction fetch is requested |
| fetch_addr | output | 49 | Byte address of the requested instruction |
| fetch_gnt | input | 1 | Fetch accepted this cycle |
| cmpl | input | 1 | One instruction completed |
| err_in | input | 7 | Single-cycle set pulses for the status bits |
| irq | output | 1 | Interrupt request |

## Verification
Every register updates at the first rising edge after the write, grant, completion or error pulse that changes it. `csr_rdata`, `fetch_req`, `fetch_addr` and `irq` follow that edge combinationally, so each result is due one cycle after its stimulus. The bench drives its inputs on falling edges and holds each for exactly one rising edge. It then reads back or samples just after the next falling edge, when every effect of that single edge has settled.

// File: rtl/iq_pkg.sv
package iq_pkg;
   localparam int CSR_ADR_W = 3;
   typedef enum logic [CSR_ADR_W-1:0] {
      SEL_CTRL   = 3'd0,
      SEL_DBELL  = 3'd1,
      SEL_BASE   = 3'd2,
      SEL_INFL   = 3'd3,
      SEL_STAT   = 3'd4,
      SEL_EN_SET = 3'd5,
      SEL_EN_CLR = 3'd6
   } csr_sel_e;
   localparam int DOVF_BIT = 1;
endpackage

// File: rtl/iq_pend_cnt.sv
module iq_pend_cnt #(
   parameter int CNT_W = 20,
   parameter int STEP  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             add_en,
   input  logic [CNT_W-1:0] add_val,
   input  logic             take,
   output logic [CNT_W-1:0] pend,
   output logic             enough,
   output logic             ovf
);
   localparam logic [CNT_W:0] STEP_X = (CNT_W+1)'(STEP);

   initial begin
      if (STEP < 1 || STEP >= (1 << CNT_W))
         $error("iq_pend_cnt: STEP out of range");
   end

   logic [CNT_W:0] sum;

   always_comb begin
      sum = {1'b0, pend};
      if (take)   sum = sum - STEP_X;
      if (add_en) sum = sum + {1'b0, add_val};
   end

   assign enough = ({1'b0, pend} >= STEP_X);
   assign ovf    = sum[CNT_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= '0;
      else        pend <= sum[CNT_W-1:0];
   end

   // R2
   take_enough_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> enough);
   // R2
   take_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take && !add_en |=> pend == $past(pend) - STEP_X[CNT_W-1:0]);
   // R1
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !take && !add_en |=> $stable(pend));
endmodule

// File: rtl/iq_fetch_trk.sv
module iq_fetch_trk #(
   parameter int ADDR_W     = 49,
   parameter int LINE_SHIFT = 6,
   parameter int INFL_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   input  logic              base_we,
   input  logic [ADDR_W-1:0] base_val,
   input  logic              fire,
   input  logic              cmpl,
   output logic [ADDR_W-1:0] addr,
   output logic [INFL_W-1:0] infl,
   output logic              infl_full
);
   localparam int PTR_W = ADDR_W - LINE_SHIFT;
   localparam logic [PTR_W-1:0]  PTR_ONE = PTR_W'(1);
   localparam logic [INFL_W-1:0] INF_ONE = INFL_W'(1);

   initial begin
      if (PTR_W < 1) $error("iq_fetch_trk: ADDR_W must exceed LINE_SHIFT");
      if (INFL_W < 1) $error("iq_fetch_trk: INFL_W must be positive");
   end

   logic [PTR_W-1:0] ptr;
   logic             locked;

   assign locked    = hold || (infl != '0);
   assign infl_full = (infl == '1);
   assign addr      = {ptr, {LINE_SHIFT{1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                ptr <= '0;
      else if (fire)             ptr <= ptr + PTR_ONE;
      else if (base_we && !locked) ptr <= base_val[ADDR_W-1:LINE_SHIFT];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            infl <= '0;
      else if (fire && !cmpl)                infl <= infl + INF_ONE;
      else if (!fire && cmpl && infl != '0)  infl <= infl - INF_ONE;
   end

   // R4
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> ptr == $past(ptr) + PTR_ONE);
   // R6
   base_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      locked && !fire |=> $stable(ptr));
   // R5
   infl_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire && !cmpl |=> infl == $past(infl) + INF_ONE);
   // R5
   infl_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire && cmpl |=> $stable(infl));
endmodule

// File: rtl/iq_misc_irq.sv
module iq_misc_irq #(
   parameter int NUM_IRQ = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] set_pulse,
   input  logic               stat_clr,
   input  logic               en_set,
   input  logic               en_clr,
   input  logic [NUM_IRQ-1:0] wbits,
   output logic [NUM_IRQ-1:0] stat,
   output logic [NUM_IRQ-1:0] en,
   output logic               irq
);
   initial begin
      if (NUM_IRQ < 2 || NUM_IRQ > 32) $error("iq_misc_irq: NUM_IRQ out of range");
   end

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     stat[i] <= 1'b0;
         else if (set_pulse[i])          stat[i] <= 1'b1;
         else if (stat_clr && wbits[i])  stat[i] <= 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                   en[i] <= 1'b0;
         else if (en_set && wbits[i])  en[i] <= 1'b1;
         else if (en_clr && wbits[i])  en[i] <= 1'b0;
      end

      // R7
      set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
         set_pulse[i] |=> stat[i]);
      // R7
      clr_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
         stat_clr && wbits[i] && !set_pulse[i] |=> !stat[i]);
   end

   assign irq = |(stat & en);

   // R8
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en == '0) |-> !irq);
endmodule

// File: rtl/iq_front.sv
module iq_front #(
   parameter int CSR_W      = 64,
   parameter int CNT_W      = 20,
   parameter int WORDS_INST = 8,
   parameter int ADDR_W     = 49,
   parameter int LINE_SHIFT = 6,
   parameter int INFL_W     = 8,
   parameter int NUM_IRQ    = 7
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          csr_we,
   input  logic [iq_pkg::CSR_ADR_W-1:0]  csr_addr,
   input  logic [CSR_W-1:0]              csr_wdata,
   output logic [CSR_W-1:0]              csr_rdata,
   output logic                          fetch_req,
   output logic [ADDR_W-1:0]             fetch_addr,
   input  logic                          fetch_gnt,
   input  logic                          cmpl,
   input  logic [NUM_IRQ-1:0]            err_in,
   output logic                          irq
);
   import iq_pkg::*;

   initial begin
      if (CSR_W < ADDR_W || CSR_W < CNT_W || CSR_W < NUM_IRQ)
         $error("iq_front: CSR_W too narrow");
      if (NUM_IRQ <= DOVF_BIT) $error("iq_front: overflow bit outside status");
   end

   logic               ena;
   logic               fire;
   logic               enough, ovf, infl_full;
   logic [CNT_W-1:0]   pend;
   logic [INFL_W-1:0]  infl;
   logic [NUM_IRQ-1:0] stat, en, set_pulse;
   logic               wr_ctrl, wr_db, wr_base, wr_stat, wr_es, wr_ec;

   assign wr_ctrl = csr_we && (csr_addr == SEL_CTRL);
   assign wr_db   = csr_we && (csr_addr == SEL_DBELL);
   assign wr_base = csr_we && (csr_addr == SEL_BASE);
   assign wr_stat = csr_we && (csr_addr == SEL_STAT);
   assign wr_es   = csr_we && (csr_addr == SEL_EN_SET);
   assign wr_ec   = csr_we && (csr_addr == SEL_EN_CLR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ena <= 1'b0;
      else if (wr_ctrl) ena <= csr_wdata[0];
   end

   assign fetch_req = ena && enough && !infl_full;
   assign fire      = fetch_req && fetch_gnt;

   iq_pend_cnt #(.CNT_W(CNT_W), .STEP(WORDS_INST)) u_pend (
      .clk(clk), .rst_n(rst_n), .add_en(wr_db), .add_val(csr_wdata[CNT_W-1:0]),
      .take(fire), .pend(pend), .enough(enough), .ovf(ovf));

   iq_fetch_trk #(.ADDR_W(ADDR_W), .LINE_SHIFT(LINE_SHIFT), .INFL_W(INFL_W)) u_trk (
      .clk(clk), .rst_n(rst_n), .hold(ena), .base_we(wr_base),
      .base_val(csr_wdata[ADDR_W-1:0]), .fire(fire), .cmpl(cmpl),
      .addr(fetch_addr), .infl(infl), .infl_full(infl_full));

   always_comb begin
      set_pulse = err_in;
      set_pulse[DOVF_BIT] = err_in[DOVF_BIT] | ovf;
   end

   iq_misc_irq #(.NUM_IRQ(NUM_IRQ)) u_irq (
      .clk(clk), .rst_n(rst_n), .set_pulse(set_pulse), .stat_clr(wr_stat),
      .en_set(wr_es), .en_clr(wr_ec), .wbits(csr_wdata[NUM_IRQ-1:0]),
      .stat(stat), .en(en), .irq(irq));

   always_comb begin
      csr_rdata = '0;
      case (csr_addr)
         SEL_CTRL:             csr_rdata[0] = ena;
         SEL_DBELL:            csr_rdata[CNT_W-1:0] = pend;
         SEL_BASE:             csr_rdata[ADDR_W-1:0] = fetch_addr;
         SEL_INFL:             csr_rdata[INFL_W-1:0] = infl;
         SEL_STAT:             csr_rdata[NUM_IRQ-1:0] = stat;
         SEL_EN_SET, SEL_EN_CLR: csr_rdata[NUM_IRQ-1:0] = en;
         default:              csr_rdata = '0;
      endcase
   end

   // R2
   req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req |-> ena && (pend >= CNT_W'(WORDS_INST)));
   // R3
   ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> stat[DOVF_BIT]);
endmodule

// File: tb/tb_iq_front.sv
module tb_iq_front;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csr_we = 1'b0;
   logic [2:0]  csr_addr = 3'd0;
   logic [63:0] csr_wdata = '0;
   logic [63:0] csr_rdata;
   logic        fetch_req;
   logic [48:0] fetch_addr;
   logic        fetch_gnt = 1'b0;
   logic        cmpl = 1'b0;
   logic [6:0]  err_in = '0;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   iq_front dut (
      .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
      .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .fetch_req(fetch_req),
      .fetch_addr(fetch_addr), .fetch_gnt(fetch_gnt), .cmpl(cmpl),
      .err_in(err_in), .irq(irq));

   // doorbell add value, expected pending count afterwards
   localparam logic [39:0] VEC [0:3] = '{
      {20'd8,  20'd8},
      {20'd16, 20'd24},
      {20'd3,  20'd27},
      {20'd5,  20'd32}
   };

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [63:0] d);
      @(negedge clk);
      csr_we = 1'b1; csr_addr = a; csr_wdata = d;
      @(negedge clk);
      csr_we = 1'b0; csr_wdata = '0;
   endtask

   task automatic rd_chk(input string tag, input logic [2:0] a, input logic [63:0] exp);
      csr_addr = a;
      #1;
      chk(tag, csr_rdata, exp);
   endtask

   task automatic grant(input int n);
      @(negedge clk);
      fetch_gnt = 1'b1;
      for (int i = 0; i < n; i++) @(negedge clk);
      fetch_gnt = 1'b0;
   endtask

   initial begin
      #1_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R9 reset state
      rd_chk("R9 pending", 3'd1, 64'd0);
      rd_chk("R9 inflight", 3'd3, 64'd0);
      rd_chk("R9 base", 3'd2, 64'd0);
      rd_chk("R9 status", 3'd4, 64'd0);
      rd_chk("R9 enables", 3'd5, 64'd0);
      rd_chk("R9 ctrl", 3'd0, 64'd0);
      chk("R9 fetch_req", {63'd0, fetch_req}, 64'd0);
      chk("R9 irq", {63'd0, irq}, 64'd0);

      // R1 doorbell table, queue disabled
      for (int i = 0; i < 4; i++) begin
         wr(3'd1, {44'd0, VEC[i][39:20]});
         rd_chk("R1 pending", 3'd1, {44'd0, VEC[i][19:0]});
         chk("R2 no req while disabled", {63'd0, fetch_req}, 64'd0);
      end

      // R4 start address
      wr(3'd2, 64'h1000);
      rd_chk("R4 base readback", 3'd2, 64'h1000);
      wr(3'd2, 64'h2027);
      rd_chk("R4 low bits dropped", 3'd2, 64'h2000);
      wr(3'd2, 64'h1000);

      // R2 enable and fetch
      wr(3'd0, 64'd1);
      chk("R2 req when enabled", {63'd0, fetch_req}, 64'd1);
      chk("R4 fetch_addr", {15'd0, fetch_addr}, 64'h1000);
      grant(1);
      rd_chk("R2 pending after grant", 3'd1, 64'd24);
      rd_chk("R4 address advanced", 3'd2, 64'h1040);
      rd_chk("R5 inflight one", 3'd3, 64'd1);

      // R6 start write ignored while enabled
      wr(3'd2, 64'h8000);
      rd_chk("R6 base locked", 3'd2, 64'h1040);

      grant(3);
      rd_chk("R2 pending drained", 3'd1, 64'd0);
      rd_chk("R5 inflight four", 3'd3, 64'd4);
      chk("R2 req low at zero", {63'd0, fetch_req}, 64'd0);
      chk("R4 fetch_addr after four", {15'd0, fetch_addr}, 64'h1100);

      // R2 partial instruction does not fetch
      wr(3'd1, 64'd3);
      chk("R2 req low below 8", {63'd0, fetch_req}, 64'd0);
      rd_chk("R1 partial accepted", 3'd1, 64'd3);

      // R5 grant and completion together
      wr(3'd1, 64'd5);
      @(negedge clk);
      fetch_gnt = 1'b1; cmpl = 1'b1;
      @(negedge clk);
      fetch_gnt = 1'b0; cmpl = 1'b0;
      rd_chk("R5 grant+cmpl unchanged", 3'd3, 64'd4);
      rd_chk("R2 pending after grant", 3'd1, 64'd0);

      // R6 disabled but still in flight
      wr(3'd0, 64'd0);
      wr(3'd2, 64'h8000);
      rd_chk("R6 locked by inflight", 3'd2, 64'h1140);

      @(negedge clk);
      cmpl = 1'b1;
      repeat (4) @(negedge clk);
      cmpl = 1'b0;
      rd_chk("R5 inflight drained", 3'd3, 64'd0);
      @(negedge clk);
      cmpl = 1'b1;
      @(negedge clk);
      cmpl = 1'b0;
      rd_chk("R5 no underflow", 3'd3, 64'd0);
      wr(3'd2, 64'h8000);
      rd_chk("R6 unlocked write", 3'd2, 64'h8000);

      // R3 overflow
      wr(3'd1, 64'd3);
      wr(3'd1, 64'hFFFFF);
      rd_chk("R3 wrapped pending", 3'd1, 64'd2);
      rd_chk("R3 overflow bit", 3'd4, 64'h2);
      chk("R8 irq masked", {63'd0, irq}, 64'd0);

      // R8 enables
      wr(3'd5, 64'h2);
      rd_chk("R8 enable set", 3'd5, 64'h2);
      chk("R8 irq raised", {63'd0, irq}, 64'd1);
      wr(3'd4, 64'h2);
      rd_chk("R7 w1c clears", 3'd4, 64'h0);
      chk("R8 irq cleared", {63'd0, irq}, 64'd0);

      // R7 set wins over clear
      wr(3'd5, 64'h8);
      @(negedge clk);
      csr_we = 1'b1; csr_addr = 3'd4; csr_wdata = 64'h8; err_in = 7'h08;
      @(negedge clk);
      csr_we = 1'b0; csr_wdata = '0; err_in = '0;
      rd_chk("R7 set wins", 3'd4, 64'h8);
      chk("R8 irq from bit3", {63'd0, irq}, 64'd1);
      wr(3'd6, 64'h8);
      rd_chk("R8 enable clear", 3'd6, 64'h2);
      chk("R8 irq after en clear", {63'd0, irq}, 64'd0);

      // R7 mailbox and fault pulses
      @(negedge clk);
      err_in = 7'h41;
      @(negedge clk);
      err_in = '0;
      rd_chk("R7 mailbox and fault", 3'd4, 64'h49);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule